// File: doc/BRIEF.md
# Per-Port LED Override Blinker

This block drives the status LEDs of a multi-port switch. Each port has six LEDs: three copper LEDs and three fibre LEDs. Each LED is driven in one of two ways. It can pass through an automatic link/activity level supplied from outside, or it can follow a 3-bit software code. A code selects off, steady on, or one of six toggle rates. The rates come from one counter that advances on a 1 ms tick input, so LEDs that share a rate stay in phase. A system LED has its own enable bit and a 2-bit mode.

Software writes over a simple write port. Each write carries a kind, a port index and an 18-bit data word. Code writes land in a staging copy. They reach the LEDs only after a commit write. A two-state commit machine handles the commit: CM_IDLE moves to CM_LOAD when a commit request arrives. CM_LOAD copies every staged code into the active codes on one edge, raises the busy flag for that one cycle, and always returns to CM_IDLE. Software-enable masks, output-enable masks and the system LED setting take effect on the edge after the write, with no staging.

Top module: `led_override_blinker`

## Requirements
- R1: After reset, every LED output, the system LED and the commit busy flag are 0, and all codes, masks and system settings are cleared.
- R2: Code 0 holds an LED at 0 and code 7 holds it at 1.
- R3: Codes 1 to 6 make the LED follow bit (code+4) of the shared tick count. The LED therefore flips every 32, 64, 128, 256, 512 and 1024 ticks respectively, in phase for LEDs that share a code.
- R4: A port code word holds LED j in bits [3j+2:3j]. j=0..2 are copper LEDs 0..2 and j=3..5 are fibre LEDs 0..2. LED j of port p appears on led_o[6p+j].
- R5: A code write (wr_kind=0) changes only the staged code and has no effect on led_o until a commit.
- R6: A write with wr_kind=4 and wr_data[0]=1 sets commit_busy_o for exactly the next cycle. On the edge that ends that cycle, all staged codes become active together. The same write with wr_data[0]=0 does nothing.
- R7: Software-enable mask bit j (wr_kind=1, wr_data[j]) set to 0 makes LED j follow auto_led_i. Set to 1, the LED follows its active code.
- R8: Output-enable mask bit j (wr_kind=2, wr_data[j]) set to 0 forces LED j to 0, whatever its code, its software enable or its automatic input.
- R9: The system LED is set with wr_kind=3, where wr_data[0] is the enable and wr_data[2:1] is the mode. Mode 0 is off. Mode 1 follows tick-count bit 5 (64-tick period). Mode 2 follows bit 9 (1024-tick period). Mode 3 is on. With the enable clear the LED is 0.
- R10: The tick count advances only on cycles with tick_1ms high. With the tick held low, every toggling output holds its level.
- R11: Writes with wr_kind 5 to 7, and port-indexed writes (kinds 0 to 2) to a port index of NUM_PORTS or more, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse once per millisecond |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 3 | Write kind: 0 code, 1 sw enable, 2 output enable, 3 system LED, 4 commit |
| wr_port | input | PORT_W | Port index for kinds 0 to 2 |
| wr_data | input | 18 | Write data |
| auto_led_i | input | NUM_PORTS*6 | Automatic link/activity levels |
| led_o | output | NUM_PORTS*6 | LED drive levels |
| sys_led_o | output | 1 | System LED drive level |
| commit_busy_o | output | 1 | High during the commit load cycle |

## Verification
The main function is exercised with three fixed code layouts: all six rates spread across one port, off and on codes mixed with rates on a second port, and one repeated rate on a third port. Each layout is checked on every cycle across a full wrap of the tick counter, which separates field positions, rate bits and phase alignment. Automatic inputs are walked through eight patterns under partial software masks, which tells the source selection apart from output gating. Staging is tested by writing codes and an inert commit and confirming the outputs do not move. The system LED is swept through all four modes, and the tick input is held low to confirm the counter freezes.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
    localparam int LEDS_PER_PORT = 6;
    localparam int CODE_W        = 3;
    localparam int WORD_W        = LEDS_PER_PORT * CODE_W;
    localparam int TB_W          = 11;
    localparam int RATE_BASE     = 4;

    typedef enum logic [2:0] {
        K_CODE   = 3'd0,
        K_SWEN   = 3'd1,
        K_OUTEN  = 3'd2,
        K_SYS    = 3'd3,
        K_COMMIT = 3'd4
    } wr_kind_e;

    typedef enum logic {
        CM_IDLE = 1'b0,
        CM_LOAD = 1'b1
    } commit_state_e;

    function automatic logic code_level(input logic [CODE_W-1:0] code,
                                        input logic [TB_W-1:0]   cnt);
        logic lvl;
        case (code)
            3'd0:    lvl = 1'b0;
            3'd7:    lvl = 1'b1;
            default: lvl = cnt[int'(code) + RATE_BASE];
        endcase
        return lvl;
    endfunction

    function automatic logic sys_level(input logic            en,
                                       input logic [1:0]      mode,
                                       input logic [TB_W-1:0] cnt);
        logic lvl;
        case (mode)
            2'd0:    lvl = 1'b0;
            2'd1:    lvl = cnt[5];
            2'd2:    lvl = cnt[9];
            default: lvl = 1'b1;
        endcase
        return en & lvl;
    endfunction
endpackage

// File: rtl/led_timebase.sv
module led_timebase
    import led_blink_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TB_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R10
    frozen_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R10
    moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt != $past(cnt));
endmodule

// File: rtl/led_commit_fsm.sv
module led_commit_fsm
    import led_blink_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic load,
    output logic busy
);
    commit_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            CM_IDLE: if (req) state_nx = CM_LOAD;
            CM_LOAD: state_nx = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= CM_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        load = 1'b0;
        busy = 1'b0;
        unique case (state)
            CM_IDLE: ;
            CM_LOAD: begin
                load = 1'b1;
                busy = 1'b1;
            end
        endcase
    end

    // R6
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6
    req_starts_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
    import led_blink_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [TB_W-1:0]   cnt,
    input  logic              auto_i,
    input  logic              sw_sel,
    input  logic              out_en,
    output logic              led
);
    always_comb begin
        if (!out_en)
            led = 1'b0;
        else if (sw_sel)
            led = code_level(code, cnt);
        else
            led = auto_i;
    end
endmodule

// File: rtl/led_override_blinker.sv
module led_override_blinker
    import led_blink_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick_1ms,
    input  logic                           wr_en,
    input  logic [2:0]                     wr_kind,
    input  logic [PORT_W-1:0]              wr_port,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [NUM_PORTS*LEDS_PER_PORT-1:0] auto_led_i,
    output logic [NUM_PORTS*LEDS_PER_PORT-1:0] led_o,
    output logic                           sys_led_o,
    output logic                           commit_busy_o
);
    localparam int LED_N = NUM_PORTS * LEDS_PER_PORT;

    logic [NUM_PORTS-1:0][WORD_W-1:0]        staged_q;
    logic [NUM_PORTS-1:0][WORD_W-1:0]        active_q;
    logic [NUM_PORTS-1:0][LEDS_PER_PORT-1:0] swen_q;
    logic [NUM_PORTS-1:0][LEDS_PER_PORT-1:0] outen_q;
    logic                                    sys_en_q;
    logic [1:0]                              sys_mode_q;
    logic [TB_W-1:0]                         cnt;
    logic                                    port_ok;
    logic                                    commit_req;
    logic                                    load;
    logic [LED_N-1:0]                        outen_flat;

    assign port_ok    = (int'(wr_port) < NUM_PORTS);
    assign commit_req = wr_en && (wr_kind == K_COMMIT) && wr_data[0];
    assign outen_flat = outen_q;

    led_timebase u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1ms),
        .cnt   (cnt)
    );

    led_commit_fsm u_commit (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (commit_req),
        .load  (load),
        .busy  (commit_busy_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q   <= '0;
            swen_q     <= '0;
            outen_q    <= '0;
            sys_en_q   <= 1'b0;
            sys_mode_q <= 2'd0;
        end else if (wr_en) begin
            case (wr_kind)
                K_CODE:  if (port_ok) staged_q[wr_port] <= wr_data;
                K_SWEN:  if (port_ok) swen_q[wr_port]   <= wr_data[LEDS_PER_PORT-1:0];
                K_OUTEN: if (port_ok) outen_q[wr_port]  <= wr_data[LEDS_PER_PORT-1:0];
                K_SYS: begin
                    sys_en_q   <= wr_data[0];
                    sys_mode_q <= wr_data[2:1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (load)
            active_q <= staged_q;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar j = 0; j < LEDS_PER_PORT; j++) begin : g_led
            led_src_mux u_mux (
                .code   (active_q[p][j*CODE_W +: CODE_W]),
                .cnt    (cnt),
                .auto_i (auto_led_i[p*LEDS_PER_PORT + j]),
                .sw_sel (swen_q[p][j]),
                .out_en (outen_q[p][j]),
                .led    (led_o[p*LEDS_PER_PORT + j])
            );
        end
    end

    assign sys_led_o = sys_level(sys_en_q, sys_mode_q, cnt);

    // R8
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_o & ~outen_flat) == '0);

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_busy_o |=> $stable(active_q));

    // R9
    sys_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en_q |-> !sys_led_o);
endmodule

// File: tb/test_led_override_blinker.sv
`timescale 1ns/1ps
module test_led_override_blinker;
    localparam int NP = 3;
    localparam int PW = 2;
    localparam int NL = NP * 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_kind = '0;
    logic [PW-1:0] wr_port = '0;
    logic [17:0]   wr_data = '0;
    logic [NL-1:0] auto_i = '0;
    logic [NL-1:0] led;
    logic          sys_led;
    logic          busy;

    int errors = 0;
    int checks = 0;

    logic [10:0] m;
    logic [17:0] b_stg [NP];
    logic [17:0] b_act [NP];
    logic [5:0]  b_sw  [NP];
    logic [5:0]  b_oe  [NP];
    logic        b_sen;
    logic [1:0]  b_smode;

    always #10 clk = ~clk;

    led_override_blinker #(.NUM_PORTS(NP), .PORT_W(PW)) i_led_override_blinker (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .wr_en(wr_en),
        .wr_kind(wr_kind), .wr_port(wr_port), .wr_data(wr_data),
        .auto_led_i(auto_i), .led_o(led), .sys_led_o(sys_led),
        .commit_busy_o(busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) m <= '0;
        else if (tick) m <= m + 1'b1;
    end

    function automatic logic lvl(input logic [2:0] c, input logic [10:0] t);
        if (c == 3'd0) return 1'b0;
        if (c == 3'd7) return 1'b1;
        return t[int'(c) + 4];
    endfunction

    function automatic logic [NL-1:0] exp_leds();
        logic [NL-1:0] v;
        for (int p = 0; p < NP; p++)
            for (int j = 0; j < 6; j++) begin
                logic s;
                s = b_sw[p][j] ? lvl(b_act[p][3*j +: 3], m) : auto_i[6*p+j];
                v[6*p+j] = b_oe[p][j] & s;
            end
        return v;
    endfunction

    function automatic logic exp_sys();
        logic s;
        case (b_smode)
            2'd0: s = 1'b0;
            2'd1: s = m[5];
            2'd2: s = m[9];
            default: s = 1'b1;
        endcase
        return b_sen & s;
    endfunction

    task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] ex);
        checks++;
        if (act !== ex) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at t=%0t", req, act, ex, $time);
        end
    endtask

    task automatic wr(input logic [2:0] k, input int port, input logic [17:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_port = PW'(port); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sweep(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, led, exp_leds());
        end
    endtask

    task automatic do_commit();
        wr(3'd4, 0, 18'd1);
        chk("R6 busy set", NL'(busy), NL'(1));
        @(negedge clk);
        chk("R6 busy clear", NL'(busy), NL'(0));
        for (int p = 0; p < NP; p++) b_act[p] = b_stg[p];
        chk("R6 load applied", led, exp_leds());
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            b_stg[p] = '0; b_act[p] = '0; b_sw[p] = '0; b_oe[p] = '0;
        end
        b_sen = 1'b0; b_smode = 2'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 leds", led, '0);
        chk("R1 sys", NL'(sys_led), NL'(0));
        chk("R1 busy", NL'(busy), NL'(0));

        for (int p = 0; p < NP; p++) begin
            wr(3'd2, p, 18'h3f); b_oe[p] = 6'h3f;
            wr(3'd1, p, 18'h3f); b_sw[p] = 6'h3f;
        end
        // R4 layout: port0 codes 1..6, port1 mixed, port2 all code 3
        b_stg[0] = {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1};
        b_stg[1] = {3'd6, 3'd1, 3'd0, 3'd7, 3'd0, 3'd7};
        b_stg[2] = {6{3'd3}};
        for (int p = 0; p < NP; p++) wr(3'd0, p, b_stg[p]);
        // R5 staged codes not visible yet
        sweep("R5 staged hidden", 40);
        // R6 commit with bit0 clear ignored
        wr(3'd4, 0, 18'h3fffe);
        chk("R6 inert commit busy", NL'(busy), NL'(0));
        sweep("R6 inert commit", 5);
        do_commit();
        // R2 R3 R4 full counter wrap
        sweep("R3 rates", 2100);

        // R10 tick held low
        @(negedge clk); tick = 1'b0;
        sweep("R10 frozen", 200);
        @(negedge clk); tick = 1'b1;

        // R7 fibre LEDs on auto
        wr(3'd1, 0, 18'h07); b_sw[0] = 6'h07;
        wr(3'd1, 1, 18'h00); b_sw[1] = 6'h00;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            auto_i = NL'(i * 18'h2493 + i);
            @(negedge clk);
            chk("R7 auto select", led, exp_leds());
        end
        // R8 output gating
        auto_i = '1;
        wr(3'd2, 1, 18'h2a); b_oe[1] = 6'h2a;
        wr(3'd2, 2, 18'h00); b_oe[2] = 6'h00;
        sweep("R8 gate", 80);

        // R11 ignored kinds and out-of-range port
        wr(3'd5, 0, 18'h3ffff);
        wr(3'd6, 0, 18'h0);
        wr(3'd7, 1, 18'h0);
        wr(3'd0, 3, 18'h0);
        wr(3'd1, 3, 18'h0);
        wr(3'd2, 3, 18'h0);
        sweep("R11 ignored", 20);
        do_commit();
        sweep("R11 after commit", 100);

        // R5 second staging round
        b_stg[0] = {6{3'd7}};
        wr(3'd0, 0, b_stg[0]);
        sweep("R5 restage hidden", 30);
        do_commit();
        sweep("R5 restage shown", 30);

        // R9 system LED modes
        for (int md = 0; md < 4; md++) begin
            b_sen = 1'b1; b_smode = 2'(md);
            wr(3'd3, 0, 18'((md << 1) | 1));
            for (int i = 0; i < 1100; i++) begin
                @(negedge clk);
                chk("R9 sys mode", NL'(sys_led), NL'(exp_sys()));
            end
        end
        b_sen = 1'b0; b_smode = 2'd3;
        wr(3'd3, 0, 18'd6);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            chk("R9 sys disabled", NL'(sys_led), NL'(0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule